// File: doc/BRIEF.md
# Prescaled Reloading Countdown Timer

This block is a 16-bit down-counting interval timer that runs from the master clock. A free-running prescaler produces a base tick once every `PRESCALE` master clocks (400 by default, which gives 20 µs at 20 MHz). A five-state phase counter groups those ticks into a slow period. The counter steps down by one on every base tick (fast rate) or once per slow period (slow rate). A step taken at zero loads a programmable reload value. Reaching zero from a nonzero value latches a zero status and can raise a level interrupt.

Software writes a byte-wide control word, and writes the reload value as a low byte and a high byte. Either reload byte write also loads the counter directly. The current count is always visible on an output. Switching from the slow rate to the fast rate in the middle of a slow period causes one extra immediate step. The block models this known quirk on purpose.

Top module: `tmr_countdown`

## Requirements
- R1: The first base tick falls on the `PRESCALE`-th rising edge after reset release, and later ticks follow every `PRESCALE` edges. The phase counter advances on each tick and runs 0,1,2,3,4,0,…
- R2: When control bit 4 (fast) and bit 0 (enable) are both 1, the counter steps on every base tick and holds between ticks.
- R3: With bit 4 at 0 (slow), the counter steps only on a tick that takes the phase from 4 back to 0.
- R4: With bit 0 at 0, the counter does not step. The prescaler and the phase still run, so the first slow step after re-enabling is aligned to the phase that kept counting.
- R5: A step taken with the counter at 0 loads the reload value. Any other step subtracts one.
- R6: A step that takes the counter from 1 to 0 sets `zero_stat`. It also sets `irq` if the interrupt enable (bit 3) was already 1 before that edge.
- R7: A control write with bit 2 set clears status only in two cases: the timer was disabled before the write, or the counter is nonzero and the written bit 0 is 0. A performed clear sets `zero_stat` to (count != 0) and drops `irq`. In all other cases the write leaves the status unchanged.
- R8: A control write with bit 3 at 0 forces `irq` low on that edge, and this takes priority over a zero event.
- R9: A control write made in slow mode that sets bit 4 while the phase is not 4 performs one immediate step, either decrement or reload. The step does not happen when the phase is 4.
- R10: Reset sets the count to 0xFFFF, the reload value to 0, the phase to 0, `zero_stat` and `irq` to 0, and all control bits to 0.
- R11: Writing the low or high reload byte updates that byte of the reload value. The same edge loads the whole new reload value into the counter, and this load takes priority over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_data | input | 8 | Control word: bit0 enable, bit2 status clear, bit3 interrupt enable, bit4 fast rate |
| rld_lo_wr | input | 1 | Write strobe for the low reload byte |
| rld_hi_wr | input | 1 | Write strobe for the high reload byte |
| rld_byte | input | 8 | Reload byte data |
| count_q | output | 16 | Current counter value |
| zero_stat | output | 1 | Zero status flag |
| irq | output | 1 | Level interrupt request |

## Verification
All results are registered:
- A control or reload write applied at one edge shows on the outputs right after that edge.
- A periodic step lands on edge k·`PRESCALE` for the k-th tick after reset. A slow-rate step additionally needs k to be a multiple of five.

The bench counts rising edges from reset release, drives and samples on falling edges, and places each check just after the edge where the change is due. Where timing matters, it also checks one edge earlier to show that nothing changed yet. The quirk step is checked one edge after the control write. The write is timed at a known phase, both where the quirk fires and where it must not.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // control word bit positions (software-visible layout)
   localparam int unsigned CTL_EN   = 0;
   localparam int unsigned CTL_CLR  = 2;
   localparam int unsigned CTL_IE   = 3;
   localparam int unsigned CTL_FAST = 4;

   typedef struct packed {
      logic fast;
      logic ie;
      logic en;
   } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned PRESCALE = 400,
   parameter int unsigned PHASES   = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick,
   output logic last_phase,
   output logic period_end
);
   localparam int unsigned PS_W = $clog2(PRESCALE);
   localparam int unsigned PH_W = $clog2(PHASES);
   localparam logic [PS_W-1:0] PS_TOP = PS_W'(PRESCALE - 1);
   localparam logic [PH_W-1:0] PH_TOP = PH_W'(PHASES - 1);

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("tmr_prescale: PRESCALE must be at least 2");
   end
   if (PHASES < 2) begin : g_bad_phases
      $error("tmr_prescale: PHASES must be at least 2");
   end

   logic [PS_W-1:0] ps_q;
   logic [PH_W-1:0] phase_q;

   assign tick       = (ps_q == '0);
   assign last_phase = (phase_q == PH_TOP);
   assign period_end = tick & last_phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_q    <= PS_TOP;
         phase_q <= '0;
      end else begin
         ps_q <= tick ? PS_TOP : ps_q - 1'b1;
         if (tick) phase_q <= last_phase ? '0 : phase_q + 1'b1;
      end
   end

   a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= PH_TOP);
   a_r1_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase_q));
   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int unsigned    CNT_W     = 16,
   parameter logic [CNT_W-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             rld_lo_wr,
   input  logic             rld_hi_wr,
   input  logic [7:0]       rld_byte,
   output logic [CNT_W-1:0] count_q,
   output logic             zero_evt
);
   localparam int unsigned HI_W = CNT_W - 8;

   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
      $error("tmr_down_counter: CNT_W must be 9..16");
   end

   logic [CNT_W-1:0] reload_q, reload_d, step_val;
   logic             rld_any;

   assign rld_any  = rld_lo_wr | rld_hi_wr;
   assign step_val = (count_q == '0) ? reload_q : count_q - 1'b1;
   assign zero_evt = step & ~rld_any & (count_q == CNT_W'(1));

   always_comb begin
      reload_d = reload_q;
      if (rld_lo_wr) reload_d[7:0]       = rld_byte;
      if (rld_hi_wr) reload_d[CNT_W-1:8] = rld_byte[HI_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= RESET_VAL;
         reload_q <= '0;
      end else begin
         reload_q <= reload_d;
         if (rld_any)   count_q <= reload_d;
         else if (step) count_q <= step_val;
      end
   end

   a_r5_zero_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !rld_any && count_q == '0) |=> count_q == $past(reload_q));
   a_r11_low_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
      rld_lo_wr |=> count_q[7:0] == $past(rld_byte));
   a_r2_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !rld_any) |=> $stable(count_q));
endmodule

// File: rtl/tmr_zero_flag.sv
module tmr_zero_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_evt,
   input  logic ie_q,
   input  logic clr_do,
   input  logic clr_val,
   input  logic ie_drop,
   output logic zero_stat,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zero_stat <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (zero_evt)    zero_stat <= 1'b1;
         else if (clr_do) zero_stat <= clr_val;

         if (ie_drop)                irq <= 1'b0;
         else if (zero_evt && ie_q)  irq <= 1'b1;
         else if (clr_do)            irq <= 1'b0;
      end
   end

   a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> zero_stat);
   a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> zero_stat);
   a_r8_ie_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ie_drop |=> !irq);
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
   parameter int unsigned PRESCALE = 400,
   parameter int unsigned PHASES   = 5,
   parameter int unsigned CNT_W    = 16,
   parameter bit          QUIRK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [7:0]       ctrl_data,
   input  logic             rld_lo_wr,
   input  logic             rld_hi_wr,
   input  logic [7:0]       rld_byte,
   output logic [CNT_W-1:0] count_q,
   output logic             zero_stat,
   output logic             irq
);
   import tmr_pkg::*;

   tmr_cfg_t cfg_q;
   logic     tick, last_phase, period_end;
   logic     tick_step, quirk_step, step_any, zero_evt;
   logic     clr_do, ie_drop, cnt_nz;
   logic     unused_ctl_bits;

   assign unused_ctl_bits = ^{ctrl_data[7:5], ctrl_data[1]};

   tmr_prescale #(.PRESCALE(PRESCALE), .PHASES(PHASES)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .last_phase(last_phase), .period_end(period_end)
   );

   assign cnt_nz    = (count_q != '0);
   assign tick_step = cfg_q.en & (cfg_q.fast ? tick : period_end);

   if (QUIRK_EN) begin : g_quirk
      assign quirk_step = ctrl_wr & ~cfg_q.fast & ctrl_data[CTL_FAST] & ~last_phase;
   end else begin : g_no_quirk
      assign quirk_step = 1'b0;
   end

   assign step_any = tick_step | quirk_step;
   assign clr_do   = ctrl_wr & ctrl_data[CTL_CLR] &
                     (~cfg_q.en | (cnt_nz & ~ctrl_data[CTL_EN]));
   assign ie_drop  = ctrl_wr & ~ctrl_data[CTL_IE];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (ctrl_wr) begin
         cfg_q.en   <= ctrl_data[CTL_EN];
         cfg_q.ie   <= ctrl_data[CTL_IE];
         cfg_q.fast <= ctrl_data[CTL_FAST];
      end
   end

   tmr_down_counter #(.CNT_W(CNT_W), .RESET_VAL('1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step_any),
      .rld_lo_wr(rld_lo_wr), .rld_hi_wr(rld_hi_wr), .rld_byte(rld_byte),
      .count_q(count_q), .zero_evt(zero_evt)
   );

   tmr_zero_flag u_flag (
      .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .ie_q(cfg_q.ie),
      .clr_do(clr_do), .clr_val(cnt_nz), .ie_drop(ie_drop),
      .zero_stat(zero_stat), .irq(irq)
   );

   a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_step && quirk_step));
   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.en && !quirk_step && !rld_lo_wr && !rld_hi_wr) |=> $stable(count_q));
   a_r7_refused_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_data[CTL_CLR] && cfg_q.en && (!cnt_nz || ctrl_data[CTL_EN])
       && !step_any) |=> $stable(zero_stat));
endmodule

// File: tb/tmr_countdown_tb_top.sv
module tmr_countdown_tb_top;
   localparam int P = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_data = '0;
   logic        rld_lo_wr = 1'b0;
   logic        rld_hi_wr = 1'b0;
   logic [7:0]  rld_byte = '0;
   logic [15:0] count_q;
   logic        zero_stat, irq;

   int unsigned ecount = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) ecount <= 0;
      else        ecount <= ecount + 1;
   end

   tmr_countdown #(.PRESCALE(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
      .rld_lo_wr(rld_lo_wr), .rld_hi_wr(rld_hi_wr), .rld_byte(rld_byte),
      .count_q(count_q), .zero_stat(zero_stat), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s @edge %0d: actual=%0h expected=%0h", req, ecount, act, exp);
      end
   endtask

   task automatic at_edge(input int unsigned n);
      while (ecount != n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_wr = 1'b1; ctrl_data = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic wr_rld(input bit hi, input logic [7:0] v);
      rld_lo_wr = !hi; rld_hi_wr = hi; rld_byte = v;
      @(negedge clk);
      rld_lo_wr = 1'b0; rld_hi_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 count", count_q, 16'hFFFF);
      chk("R10 zero_stat", zero_stat, 0);
      chk("R10 irq", irq, 0);
   endtask

   task automatic t_reload();
      at_edge(1*P);
      wr_rld(1'b0, 8'h03);
      wr_rld(1'b1, 8'h00);
      chk("R11 count loaded", count_q, 3);
   endtask

   task automatic t_fast_count();
      at_edge(4*P);
      chk("R4 no step while disabled", count_q, 3);
      wr_ctrl(8'h11);                      // phase 4: no quirk
      at_edge(5*P - 1);
      chk("R1 no step before tick", count_q, 3);
      at_edge(5*P);
      chk("R2 step on tick", count_q, 2);
      at_edge(6*P);
      chk("R2 second step", count_q, 1);
      at_edge(7*P);
      chk("R2 reach zero", count_q, 0);
      chk("R6 zero_stat set", zero_stat, 1);
      chk("R6 no irq when ie off", irq, 0);
   endtask

   task automatic t_status_clear();
      wr_ctrl(8'h15);                      // enabled, count 0, en written 1
      chk("R7 clear refused", zero_stat, 1);
      wr_ctrl(8'h10);                      // disable
      wr_ctrl(8'h14);                      // clear while disabled
      chk("R7 clear done", zero_stat, 0);
      at_edge(8*P);
      chk("R4 disabled holds at zero", count_q, 0);
      wr_ctrl(8'h19);
      at_edge(9*P);
      chk("R5 reload from zero", count_q, 3);
      chk("R5 reload no zero event", zero_stat, 0);
   endtask

   task automatic t_irq();
      at_edge(12*P);
      chk("R6 count zero", count_q, 0);
      chk("R6 irq raised", irq, 1);
      wr_ctrl(8'h1D);
      chk("R7 refused keeps irq", irq, 1);
      wr_ctrl(8'h11);
      chk("R8 ie clear drops irq", irq, 0);
      chk("R8 status kept", zero_stat, 1);
      wr_ctrl(8'h19);
      at_edge(16*P);
      chk("R6 irq raised again", irq, 1);
      wr_ctrl(8'h18);
      wr_ctrl(8'h1C);
      chk("R7 clear drops irq", irq, 0);
      chk("R7 clear with zero count", zero_stat, 0);
   endtask

   task automatic t_slow_and_quirk();
      wr_ctrl(8'h01);                      // slow rate, phase 1
      at_edge(19*P);
      chk("R3 no step mid-period", count_q, 0);
      at_edge(20*P - 1);
      chk("R3 hold before period end", count_q, 0);
      at_edge(20*P);
      chk("R3 period-end reload", count_q, 3);
      at_edge(25*P - 1);
      chk("R3 hold a full period", count_q, 3);
      at_edge(25*P);
      chk("R3 period-end step", count_q, 2);
      at_edge(26*P);                       // phase 1
      wr_ctrl(8'h11);
      chk("R9 quirk extra step", count_q, 1);
      at_edge(27*P);
      chk("R9 fast after switch", count_q, 0);
      chk("R6 flag on quirk path", zero_stat, 1);
      wr_ctrl(8'h01);
      at_edge(29*P);                       // phase 4
      wr_ctrl(8'h11);
      chk("R9 no quirk at phase 4", count_q, 0);
      at_edge(30*P);
      chk("R5 fast reload", count_q, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_reload();
      t_fast_count();
      t_status_clear();
      t_irq();
      t_slow_and_quirk();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule